// File: doc/BRIEF.md
# Single-Wire Bus ROM Search Sequencer

This block enumerates the devices on a single-wire bus and selects one of them. It does not time the bus slots itself. Instead it asks a separate slot engine for one slot at a time: a bus reset, a read slot, or a write slot carrying one data bit. A search pass walks the binary tree of 64-bit device codes. At every bit position it reads the bit and its complement from all devices, which the bus wired-ANDs together. It then picks a direction and writes that direction back, so that devices on the other branch drop out. The pass yields one complete device code and a new last-discrepancy position.

To enumerate the bus, software runs a pass with last-discrepancy 0 and keeps the reported code. It then runs further passes, each fed with the last-discrepancy value of the previous pass, until a pass reports 0. A select operation issues a reset, the match command and a full 64-bit code, which leaves only that device listening.

The controller is a state machine with eight states. **IDLE** waits and goes to BUSRST on `start`. **BUSRST** requests a reset slot and goes to CMD on acknowledge. **CMD** sends the command bits and then goes to RD_TRUE (search) or WR_ROM (select). **RD_TRUE** reads the true bit and goes to RD_COMP. **RD_COMP** reads the complement bit. It goes to FIN on a conflict and to WR_DIR otherwise. **WR_DIR** writes the chosen direction. It goes back to RD_TRUE, or to FIN after the last position. **WR_ROM** writes the code bits and goes to FIN after the last one. **FIN** lasts one cycle and returns to IDLE.

Top module: `onewire_search_seq`

## Requirements
- R1: A `start` pulse seen in IDLE makes `busy` high from the next cycle, with op 0 meaning search and op 1 meaning select. The first slot requested is a bus reset. A `start` while `busy` is high is ignored. After reset `busy`, `done`, `fail`, `slot_req`, `rom_out` and `last_out` are all 0.
- R2: After the reset slot, a search sends the command byte 0xF0 as 8 write slots, least-significant bit first.
- R3: For each of the 64 code positions, in ascending order, a search issues two read slots (true bit, then complement) before one write slot.
- R4: If both reads of a position return 1, the pass ends at once with `fail` = 1 and `last_out` = 0, and no further slot is issued. `fail` holds until the next start.
- R5: If both reads return 0, the direction depends on where the position index lies against the last-discrepancy input. At an equal index the direction is 1. Above it, the direction is 0 and the index becomes the new discrepancy. Below it, the direction is the bit the previous pass left in `rom_out`, and the index becomes the new discrepancy when that bit is 0.
- R6: If the two reads differ, the direction is the first read value.
- R7: The direction chosen at position i is written as the write slot for i and lands in `rom_out[i]`. The family code is in `rom_out[7:0]` and the check byte in `rom_out[63:56]`.
- R8: `last_out` at the end of a search is the highest position recorded as a discrepancy in that pass, or 0. A value of 0 means the pass found the final device, so chained passes list every device exactly once.
- R9: A select sends a reset, then 0x55 as 8 write slots least-significant bit first, then the 64 bits of `rom_in` from bit 0 up (lowest byte first, each byte least-significant bit first).
- R10: `done` is high for exactly one cycle, one cycle after the final slot is acknowledged, and `busy` falls with it. A select leaves `rom_out` and `last_out` unchanged.
- R11: `slot_req` is held, with `slot_cmd` and `slot_wbit` stable, until a one-cycle `slot_ack` completes that slot, and each acknowledge completes exactly one slot. `slot_cmd` uses 0 for reset, 1 for read and 2 for write. `slot_rbit` is sampled with the acknowledge of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 1 | 0 = search pass, 1 = select |
| last_in | input | 6 | Last-discrepancy position from the previous pass |
| rom_in | input | 64 | Device code to select |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Search aborted on a read conflict |
| rom_out | output | 64 | Code resolved by the search |
| last_out | output | 6 | New last-discrepancy position |
| slot_req | output | 1 | Slot request to the slot engine |
| slot_cmd | output | 2 | Slot kind: 0 reset, 1 read, 2 write |
| slot_wbit | output | 1 | Bit to send in a write slot |
| slot_ack | input | 1 | Slot completed (one cycle) |
| slot_rbit | input | 1 | Bus value returned by a read slot |

## Verification
The bench builds the block with its default parameters: 64-bit codes, 8-bit commands, 0xF0 for search and 0x55 for select. This puts full-length codes and both command encodings within reach. A bus model with three devices shares a family code and splits at several higher positions. Its chained passes therefore hit the equal, above and below rules of the two-zeros case. A single-device bus and an empty bus reach the final-device and conflict outcomes.

// File: rtl/ows_pkg.sv
package ows_pkg;

    typedef enum logic [1:0] {
        SLOT_RESET = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_WRITE = 2'd2
    } slot_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSRST,
        ST_CMD,
        ST_RD_TRUE,
        ST_RD_COMP,
        ST_WR_DIR,
        ST_WR_ROM,
        ST_FIN
    } seq_state_e;

endpackage

// File: rtl/ows_resolve.sv
module ows_resolve #(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] last,
    input  logic             rd_true,
    input  logic             rd_comp,
    input  logic             prev_bit,
    output logic             conflict,
    output logic             dir_bit,
    output logic             mark
);

    // Branch choice for one code position from the two wired-AND reads.
    always_comb begin
        conflict = rd_true & rd_comp;
        dir_bit  = rd_true;
        mark     = 1'b0;
        if (!rd_true && !rd_comp) begin
            if (idx == last) begin
                dir_bit = 1'b1;
            end else if (idx > last) begin
                dir_bit = 1'b0;
                mark    = 1'b1;
            end else begin
                dir_bit = prev_bit;
                mark    = ~prev_bit;
            end
        end
    end

endmodule

// File: rtl/ows_counter.sv
module ows_counter #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + W'(1);
        end
    end

endmodule

// File: rtl/ows_txsel.sv
module ows_txsel #(
    parameter int                  ROM_BITS   = 64,
    parameter int                  IDX_W      = 6,
    parameter int                  CMD_BITS   = 8,
    parameter logic [CMD_BITS-1:0] SEARCH_CMD = 8'hF0,
    parameter logic [CMD_BITS-1:0] MATCH_CMD  = 8'h55
) (
    input  logic                phase_cmd,
    input  logic                phase_rom,
    input  logic                op_sel,
    input  logic [IDX_W-1:0]    cnt,
    input  logic                dir_bit,
    input  logic [ROM_BITS-1:0] sel_rom,
    output logic                wbit
);

    localparam int CB_W = $clog2(CMD_BITS);

    logic [CMD_BITS-1:0] cmd_byte;

    assign cmd_byte = op_sel ? MATCH_CMD : SEARCH_CMD;

    // Command and code bits leave least-significant bit first.
    always_comb begin
        if (phase_cmd) begin
            wbit = cmd_byte[cnt[CB_W-1:0]];
        end else if (phase_rom) begin
            wbit = sel_rom[cnt];
        end else begin
            wbit = dir_bit;
        end
    end

endmodule

// File: rtl/onewire_search_seq.sv
module onewire_search_seq
    import ows_pkg::*;
#(
    parameter int                  ROM_BITS   = 64,
    parameter int                  CMD_BITS   = 8,
    parameter logic [CMD_BITS-1:0] SEARCH_CMD = 8'hF0,
    parameter logic [CMD_BITS-1:0] MATCH_CMD  = 8'h55
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         op,
    input  logic [$clog2(ROM_BITS)-1:0]  last_in,
    input  logic [ROM_BITS-1:0]          rom_in,
    output logic                         busy,
    output logic                         done,
    output logic                         fail,
    output logic [ROM_BITS-1:0]          rom_out,
    output logic [$clog2(ROM_BITS)-1:0]  last_out,
    output logic                         slot_req,
    output logic [1:0]                   slot_cmd,
    output logic                         slot_wbit,
    input  logic                         slot_ack,
    input  logic                         slot_rbit
);

    localparam int               IDX_W    = $clog2(ROM_BITS);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_BITS - 1);
    localparam logic [IDX_W-1:0] ROM_LAST = IDX_W'(ROM_BITS - 1);

    seq_state_e          state_q, state_d;
    logic                op_q;
    logic                rd_true_q;
    logic                dir_q;
    logic                fail_q;
    logic [ROM_BITS-1:0] rom_q;
    logic [ROM_BITS-1:0] sel_q;
    logic [IDX_W-1:0]    last_q;
    logic [IDX_W-1:0]    disc_q;
    logic [IDX_W-1:0]    cnt;
    logic                slot_done;
    logic                cnt_clr, cnt_inc;
    logic                conflict, res_bit, res_mark;
    logic                cnt_at_cmd_end, cnt_at_rom_end;

    assign slot_done      = slot_req & slot_ack;
    assign cnt_at_cmd_end = (cnt == CMD_LAST);
    assign cnt_at_rom_end = (cnt == ROM_LAST);

    ows_resolve #(.IDX_W(IDX_W)) u_resolve (
        .idx      (cnt),
        .last     (last_q),
        .rd_true  (rd_true_q),
        .rd_comp  (slot_rbit),
        .prev_bit (rom_q[cnt]),
        .conflict (conflict),
        .dir_bit  (res_bit),
        .mark     (res_mark)
    );

    assign cnt_clr = slot_done &&
                     ((state_q == ST_BUSRST) || (state_q == ST_CMD && cnt_at_cmd_end));
    assign cnt_inc = slot_done &&
                     ((state_q == ST_CMD) || (state_q == ST_WR_DIR) || (state_q == ST_WR_ROM));

    ows_counter #(.W(IDX_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .q     (cnt)
    );

    ows_txsel #(
        .ROM_BITS   (ROM_BITS),
        .IDX_W      (IDX_W),
        .CMD_BITS   (CMD_BITS),
        .SEARCH_CMD (SEARCH_CMD),
        .MATCH_CMD  (MATCH_CMD)
    ) u_txsel (
        .phase_cmd (state_q == ST_CMD),
        .phase_rom (state_q == ST_WR_ROM),
        .op_sel    (op_q),
        .cnt       (cnt),
        .dir_bit   (dir_q),
        .sel_rom   (sel_q),
        .wbit      (slot_wbit)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = ST_BUSRST;
            ST_BUSRST:  if (slot_done) state_d = ST_CMD;
            ST_CMD:     if (slot_done && cnt_at_cmd_end) state_d = op_q ? ST_WR_ROM : ST_RD_TRUE;
            ST_RD_TRUE: if (slot_done) state_d = ST_RD_COMP;
            ST_RD_COMP: if (slot_done) state_d = conflict ? ST_FIN : ST_WR_DIR;
            ST_WR_DIR:  if (slot_done) state_d = cnt_at_rom_end ? ST_FIN : ST_RD_TRUE;
            ST_WR_ROM:  if (slot_done && cnt_at_rom_end) state_d = ST_FIN;
            ST_FIN:     state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_FIN);
        slot_req = 1'b0;
        slot_cmd = SLOT_WRITE;
        unique case (state_q)
            ST_IDLE, ST_FIN: begin
                slot_req = 1'b0;
            end
            ST_BUSRST: begin
                slot_req = 1'b1;
                slot_cmd = SLOT_RESET;
            end
            ST_RD_TRUE, ST_RD_COMP: begin
                slot_req = 1'b1;
                slot_cmd = SLOT_READ;
            end
            ST_CMD, ST_WR_DIR, ST_WR_ROM: begin
                slot_req = 1'b1;
                slot_cmd = SLOT_WRITE;
            end
        endcase
    end

    // Operation context and search results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q      <= 1'b0;
            rd_true_q <= 1'b0;
            dir_q     <= 1'b0;
            fail_q    <= 1'b0;
            rom_q     <= '0;
            sel_q     <= '0;
            last_q    <= '0;
            disc_q    <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                op_q   <= op;
                sel_q  <= rom_in;
                last_q <= last_in;
                fail_q <= 1'b0;
                if (!op) disc_q <= '0;
            end
            if (state_q == ST_RD_TRUE && slot_done) begin
                rd_true_q <= slot_rbit;
            end
            if (state_q == ST_RD_COMP && slot_done) begin
                if (conflict) begin
                    fail_q <= 1'b1;
                    disc_q <= '0;
                end else begin
                    dir_q      <= res_bit;
                    rom_q[cnt] <= res_bit;
                    if (res_mark) disc_q <= cnt;
                end
            end
        end
    end

    assign fail     = fail_q;
    assign rom_out  = rom_q;
    assign last_out = disc_q;

endmodule

// File: rtl/ows_chk.sv
module ows_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             fail,
    input logic             slot_req,
    input logic             slot_ack,
    input logic [1:0]       slot_cmd,
    input logic             slot_wbit,
    input logic [IDX_W-1:0] last_out
);

    // R1: an accepted start raises busy on the next cycle
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R4: a failed search reports no discrepancy
    p_fail_last_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (last_out == '0));

    // R10: done is a single-cycle pulse and busy falls with it
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R11: slot requests only while busy
    p_req_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |-> busy);

    // R11: an unacknowledged request is held with stable kind and bit
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_ack) |=> (slot_req && $stable(slot_cmd) && $stable(slot_wbit)));

    // R11: slot kind is one of the three legal codes
    p_cmd_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        slot_req |-> (slot_cmd != 2'd3));

endmodule

bind onewire_search_seq ows_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .slot_req  (slot_req),
    .slot_ack  (slot_ack),
    .slot_cmd  (slot_cmd),
    .slot_wbit (slot_wbit),
    .last_out  (last_out)
);

// File: tb/onewire_search_seq_tb.sv
module onewire_search_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ROM_BITS   = 64;
    localparam int IDX_W      = 6;
    localparam logic [63:0] D0 = 64'h110000000000AA28;
    localparam logic [63:0] D1 = 64'h220000000000A228;
    localparam logic [63:0] D2 = 64'h330000000001AA28;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                op = 1'b0;
    logic [IDX_W-1:0]    last_in = '0;
    logic [ROM_BITS-1:0] rom_in = '0;
    logic                slot_ack = 1'b0;
    logic                slot_rbit = 1'b0;
    logic                busy, done, fail, slot_req, slot_wbit;
    logic [ROM_BITS-1:0] rom_out;
    logic [IDX_W-1:0]    last_out;
    logic [1:0]          slot_cmd;

    onewire_search_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .last_in(last_in),
        .rom_in(rom_in), .busy(busy), .done(done), .fail(fail), .rom_out(rom_out),
        .last_out(last_out), .slot_req(slot_req), .slot_cmd(slot_cmd),
        .slot_wbit(slot_wbit), .slot_ack(slot_ack), .slot_rbit(slot_rbit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;

    logic [63:0] dev_rom [4];
    int          dev_n = 0;

    logic [2:0]  exp_q [$];
    string       tag_q [$];
    logic [63:0] exp_rom = '0;
    logic [IDX_W-1:0] exp_disc = '0;
    logic        exp_fail = 1'b0;
    int          pending = 0;
    int          mstate = 0;

    // bus model state
    int   eng_phase = 3;
    int   eng_cnt = 0;
    int   eng_idx = 0;
    int   eng_sub = 0;
    logic [7:0] eng_cmd = '0;
    bit   eng_act [4];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic push(input logic [1:0] c, input logic w, input string t);
        exp_q.push_back({c, w});
        tag_q.push_back(t);
    endtask

    // expected slot sequence of a search pass over the bench's device set
    task automatic build_search(input logic [IDX_W-1:0] lastv);
        bit alive [4];
        logic [63:0] prev;
        logic a, b, dir;
        string t;
        prev = exp_rom;
        exp_q.delete(); tag_q.delete();
        exp_disc = '0; exp_fail = 1'b0;
        for (int d = 0; d < 4; d++) alive[d] = (d < dev_n);
        push(2'd0, 1'b0, "R1");
        for (int i = 0; i < 8; i++) push(2'd2, 1'((8'hF0 >> i) & 8'h1), "R2");
        for (int idx = 0; idx < 64; idx++) begin
            a = 1'b1; b = 1'b1;
            for (int d = 0; d < 4; d++) if (alive[d]) begin
                a = a & dev_rom[d][idx];
                b = b & ~dev_rom[d][idx];
            end
            push(2'd1, 1'b0, "R3");
            push(2'd1, 1'b0, "R3");
            if (a && b) begin
                exp_fail = 1'b1;
                exp_disc = '0;
                return;
            end
            if (!a && !b) begin
                t = "R5";
                if (idx == int'(lastv)) dir = 1'b1;
                else if (idx > int'(lastv)) begin dir = 1'b0; exp_disc = IDX_W'(idx); end
                else begin
                    dir = prev[idx];
                    if (!dir) exp_disc = IDX_W'(idx);
                end
            end else begin
                t = "R6";
                dir = a;
            end
            exp_rom[idx] = dir;
            push(2'd2, dir, t);
            for (int d = 0; d < 4; d++) if (alive[d] && dev_rom[d][idx] != dir) alive[d] = 0;
        end
    endtask

    task automatic build_select(input logic [63:0] romv);
        exp_q.delete(); tag_q.delete();
        exp_fail = 1'b0;
        push(2'd0, 1'b0, "R9");
        for (int i = 0; i < 8; i++) push(2'd2, 1'((8'h55 >> i) & 8'h1), "R9");
        for (int i = 0; i < 64; i++) push(2'd2, romv[i], "R9");
    endtask

    // devices on the bus: wired-AND of every listening device
    task automatic eng_slot(input logic [1:0] c, input logic wb, output logic r);
        r = 1'b1;
        if (c == 2'd0) begin
            for (int d = 0; d < 4; d++) eng_act[d] = (d < dev_n);
            eng_phase = 0; eng_cnt = 0; eng_cmd = '0; eng_idx = 0; eng_sub = 0;
        end else if (c == 2'd2) begin
            if (eng_phase == 0) begin
                eng_cmd[eng_cnt] = wb;
                eng_cnt++;
                if (eng_cnt == 8) begin
                    eng_phase = (eng_cmd == 8'hF0) ? 1 : (eng_cmd == 8'h55) ? 2 : 3;
                    eng_idx = 0; eng_sub = 0;
                end
            end else if ((eng_phase == 1 && eng_sub == 2) || eng_phase == 2) begin
                if (eng_idx < 64) begin
                    for (int d = 0; d < 4; d++)
                        if (eng_act[d] && dev_rom[d][eng_idx] != wb) eng_act[d] = 0;
                end
                eng_idx++; eng_sub = 0;
            end
        end else if (c == 2'd1 && eng_phase == 1 && eng_idx < 64) begin
            for (int d = 0; d < 4; d++) if (eng_act[d]) begin
                if (eng_sub == 0) r = r & dev_rom[d][eng_idx];
                else              r = r & ~dev_rom[d][eng_idx];
            end
            eng_sub++;
        end
    endtask

    task automatic engine();
        logic [1:0] c;
        logic wb, r;
        logic [2:0] e;
        string t;
        int w;
        forever begin
            @(negedge clk);
            if (rst_n && slot_req) begin
                w = $urandom_range(0, 2);
                repeat (w) @(negedge clk);
                c = slot_cmd; wb = slot_wbit;
                eng_slot(c, wb, r);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected slot", 64'(c), 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(c == e[2:1], t, "slot kind", 64'(c), 64'(e[2:1]));
                    if (e[2:1] == 2'd2)
                        check(wb == e[0], t, "write bit", 64'(wb), 64'(e[0]));
                end
                slot_rbit = r;
                slot_ack = 1'b1;
                @(negedge clk);
                slot_ack = 1'b0;
            end
        end
    endtask

    initial engine();

    // cycle model of busy/done
    always @(posedge clk) begin
        if (!rst_n) mstate = 0;
        else begin
            case (mstate)
                0: if (start) mstate = 1;
                1: if (slot_ack) begin
                       pending = pending - 1;
                       if (pending <= 0) mstate = 2;
                   end
                default: mstate = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(busy == (mstate != 0), "R10", "busy vs model", 64'(busy), 64'(mstate != 0));
            check(done == (mstate == 2), "R10", "done vs model", 64'(done), 64'(mstate == 2));
        end
    end

    task automatic run_pass(input logic opv, input logic [IDX_W-1:0] lastv,
                            input logic [63:0] romv, input bit poke);
        if (opv) build_select(romv); else build_search(lastv);
        pending = exp_q.size();
        @(negedge clk);
        op = opv; last_in = lastv; rom_in = romv; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1; op = ~opv; last_in = ~lastv; rom_in = ~romv;
            @(negedge clk);
            start = 1'b0; op = opv; last_in = lastv; rom_in = romv;
        end
        while (done !== 1'b1) @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, "R11", "slots left over", 64'(exp_q.size()), 64'd0);
        check(fail == exp_fail, "R4", "fail flag", 64'(fail), 64'(exp_fail));
        check(last_out == exp_disc, "R8", "last_out", 64'(last_out), 64'(exp_disc));
        if (!exp_fail)
            check(rom_out == exp_rom, "R7", "rom_out", rom_out, exp_rom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R11 watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] found [5];
        logic [63:0] rom_keep;
        logic [IDX_W-1:0] lastv;
        int nfound;
        int cnt;

        dev_rom[0] = D0; dev_rom[1] = D1; dev_rom[2] = D2; dev_rom[3] = '0;
        dev_n = 3;
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && fail == 0 && slot_req == 0, "R1", "reset controls",
              {60'd0, busy, done, fail, slot_req}, 64'd0);
        check(rom_out == '0 && last_out == '0, "R1", "reset results",
              rom_out | 64'(last_out), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // enumerate three devices; first pass also gets a start while busy (R1)
        lastv = '0; nfound = 0;
        for (int p = 0; p < 5; p++) begin
            run_pass(1'b0, lastv, 64'd0, p == 0);
            found[nfound] = rom_out; nfound++;
            lastv = last_out;
            if (lastv == '0) break;
        end
        check(nfound == 3, "R8", "device count", 64'(nfound), 64'd3);
        for (int d = 0; d < 3; d++) begin
            cnt = 0;
            for (int k = 0; k < nfound; k++) if (found[k] == dev_rom[d]) cnt++;
            check(cnt == 1, "R8", "device listed once", 64'(cnt), 64'd1);
        end
        check(found[0][7:0] == 8'h28, "R7", "family byte", 64'(found[0][7:0]), 64'h28);

        // single device: one pass, final
        dev_n = 1; dev_rom[0] = D2;
        run_pass(1'b0, '0, 64'd0, 1'b0);
        check(last_out == '0 && rom_out == D2, "R8", "single device final", rom_out, D2);

        // empty bus: both reads high
        dev_n = 0;
        run_pass(1'b0, '0, 64'd0, 1'b0);
        check(fail == 1'b1, "R4", "empty bus fails", 64'(fail), 64'd1);

        // select device D1, results unchanged
        dev_rom[0] = D0; dev_rom[1] = D1; dev_rom[2] = D2; dev_n = 3;
        rom_keep = rom_out;
        run_pass(1'b1, '0, D1, 1'b0);
        check(rom_out == rom_keep, "R10", "rom_out kept by select", rom_out, rom_keep);
        check(last_out == '0, "R10", "last_out kept by select", 64'(last_out), 64'd0);
        cnt = 0;
        for (int d = 0; d < 3; d++) if (eng_act[d]) cnt++;
        check(cnt == 1 && eng_act[1], "R9", "one device selected", 64'(cnt), 64'd1);

        // fresh search after select clears fail
        run_pass(1'b0, '0, 64'd0, 1'b0);
        check(fail == 1'b0, "R4", "fail cleared by next start", 64'(fail), 64'd0);

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule